// File: doc/BRIEF.md
# Write-Protection Unlock Command Sequencer

This block sits between a byte-wide host write port and the write controller of a 32K-byte nonvolatile array. It watches every host write (address, data, strobe) for a fixed three-write unlock command. After a complete command it opens a page-load window. The window forwards up to `PAGE_BYTES` byte loads to the array, all within one page. The window closes when no load arrives within `BLC_CYC` cycles. A timed internal write cycle of `WC_CYC` cycles follows, and the block then returns to idle with protection armed.

The protection flag models a persistent bit. A power-on reset does not clear it, and it starts at `INIT_PROT` on the first-ever power-up. Until an unlock command has been used, an unprotected part forwards ordinary writes straight into a single-page window. No write path ever clears the flag.

States: `ST_IDLE` (waiting), `ST_CMD1` (first command write seen), `ST_CMD2` (second command write seen), `ST_LOAD` (page window open), `ST_PROG` (internal write cycle, busy).

Transitions:
- IDLE→CMD1 on the first command write.
- IDLE→LOAD on any other write while unprotected.
- CMD1→CMD2 on the second command write.
- CMD2→LOAD on the third command write.
- CMD1/CMD2→CMD1 on a write of 0xAA to 0x5555.
- CMD1/CMD2→IDLE on any other write.
- LOAD→PROG when the window timer expires after at least one load.
- LOAD→IDLE when the window timer expires with no load.
- PROG→IDLE when the write-cycle timer expires.

Top module: `wp_unlock_seq`

## Requirements
- R1: While `rst_n` is low and in the cycles after its release, `busy` is 0, `arr_we` is 0 and the sequencer is idle.
- R2: The protection flag `wp_on` starts at parameter `INIT_PROT` (default 0) and is not changed by `rst_n`.
- R3: While `wp_on` is 0 and the sequencer is idle, a host write that is not 0xAA to 0x5555 is forwarded: `arr_we` pulses one cycle after the write with the same address and data, and a page window opens.
- R4: The unlock command is three consecutive host writes: 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. None of these command writes is forwarded to the array.
- R5: While `wp_on` is 1, a host write outside a completed unlock command produces no `arr_we` pulse.
- R6: A write that does not match the expected command step aborts the sequence and is not forwarded. If that write is 0xAA to 0x5555, it counts as step one of a new attempt.
- R7: An open window forwards at most `PAGE_BYTES` (default 128) loads. Further loads in the same window are ignored.
- R8: The page is fixed by address bits [14:log2(PAGE_BYTES)] of the first load. Later loads to another page are ignored.
- R9: A window closes when `BLC_CYC` cycles pass after the last accepted load without another one. `busy` then rises and stays high for exactly `WC_CYC` cycles.
- R10: While `busy` is 1, every host write is ignored, including unlock command writes.
- R11: When a write cycle follows a window opened by the unlock command, `wp_on` becomes 1 and stays 1.
- R12: A window that closes with no load starts no write cycle and leaves `wp_on` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset (does not touch the protection flag) |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 15 | Host write address |
| host_data | input | 8 | Host write data |
| arr_we | output | 1 | Byte-load strobe to the array write controller |
| arr_addr | output | 15 | Forwarded byte address |
| arr_data | output | 8 | Forwarded byte data |
| busy | output | 1 | Internal write cycle in progress |
| wp_on | output | 1 | Persistent protection flag |

## Verification
The hardest situation to reach is a complete, well-formed unlock command issued while the internal write cycle is still running. It can only be produced right after a window has closed. The bench fills a page to overflow, waits for `busy` to rise, and during the write cycle issues the three command writes and a data byte. After `busy` falls it shows that a fresh data write is still blocked, which proves the command was never taken. Persistence of the flag is reached by pulsing `rst_n` after protection is armed and observing `wp_on` together with a blocked write.

// File: rtl/wpu_pkg.sv
package wpu_pkg;
    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] CMD_ADDR_HI = 15'h5555;
    localparam logic [ADDR_W-1:0] CMD_ADDR_LO = 15'h2AAA;
    localparam logic [DATA_W-1:0] CMD_KEY_1   = 8'hAA;
    localparam logic [DATA_W-1:0] CMD_KEY_2   = 8'h55;
    localparam logic [DATA_W-1:0] CMD_KEY_3   = 8'hA0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD1,
        ST_CMD2,
        ST_LOAD,
        ST_PROG
    } wpu_state_e;

    typedef struct packed {
        logic step1;
        logic step2;
        logic step3;
    } cmd_hit_t;
endpackage

// File: rtl/wpu_cmd_match.sv
module wpu_cmd_match
    import wpu_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output cmd_hit_t          hit
);
    always_comb begin
        hit.step1 = (addr == CMD_ADDR_HI) && (data == CMD_KEY_1);
        hit.step2 = (addr == CMD_ADDR_LO) && (data == CMD_KEY_2);
        hit.step3 = (addr == CMD_ADDR_HI) && (data == CMD_KEY_3);
    end
endmodule

// File: rtl/wpu_timer.sv
module wpu_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    AST_TMR_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R9
endmodule

// File: rtl/wpu_prot_flag.sv
module wpu_prot_flag #(
    parameter bit INIT_PROT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    output logic flag
);
    // Persistent bit: initial value models the first-ever power-up,
    // deliberately outside the reset domain.
    logic flag_q = INIT_PROT;

    always_ff @(posedge clk) begin
        if (set) begin
            flag_q <= 1'b1;
        end
    end

    assign flag = flag_q;

    AST_PROT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |=> flag_q); // R11
endmodule

// File: rtl/wp_unlock_seq.sv
module wp_unlock_seq
    import wpu_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int BLC_CYC    = 1600,
    parameter int WC_CYC     = 50000,
    parameter bit INIT_PROT  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [14:0]       host_addr,
    input  logic [7:0]        host_data,
    output logic              arr_we,
    output logic [14:0]       arr_addr,
    output logic [7:0]        arr_data,
    output logic              busy,
    output logic              wp_on
);
    localparam int OFS_W   = $clog2(PAGE_BYTES);
    localparam int PG_W    = ADDR_W - OFS_W;
    localparam int LCNT_W  = $clog2(PAGE_BYTES + 1);
    localparam int TMR_MAX = (BLC_CYC > WC_CYC) ? BLC_CYC : WC_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [TMR_W-1:0]  BLC_LD   = TMR_W'(BLC_CYC - 1);
    localparam logic [TMR_W-1:0]  WC_LD    = TMR_W'(WC_CYC - 1);
    localparam logic [LCNT_W-1:0] PAGE_MAX = LCNT_W'(PAGE_BYTES);

    wpu_state_e        state_q, state_d;
    cmd_hit_t          hit;
    logic              tmr_load, tmr_zero;
    logic [TMR_W-1:0]  tmr_val;
    logic              accept, open_unlock, prot_set, load_ok;
    logic              unlock_q;
    logic [PG_W-1:0]   page_q;
    logic [LCNT_W-1:0] lcnt_q;
    logic              arr_we_q;
    logic [ADDR_W-1:0] arr_addr_q;
    logic [DATA_W-1:0] arr_data_q;
    logic              wp_flag;

    wpu_cmd_match u_match (
        .addr (host_addr),
        .data (host_data),
        .hit  (hit)
    );

    wpu_timer #(.CNT_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    wpu_prot_flag #(.INIT_PROT(INIT_PROT)) u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (prot_set),
        .flag  (wp_flag)
    );

    // A load is admissible if it is the first of the window, or it
    // hits the latched page while room remains.
    assign load_ok = (lcnt_q == '0) ||
                     ((host_addr[ADDR_W-1:OFS_W] == page_q) && (lcnt_q < PAGE_MAX));

    // Next-state and control decode
    always_comb begin
        state_d     = state_q;
        accept      = 1'b0;
        open_unlock = 1'b0;
        prot_set    = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = BLC_LD;
        unique case (state_q)
            ST_IDLE: begin
                if (host_we) begin
                    if (hit.step1) begin
                        state_d = ST_CMD1;
                    end else if (!wp_flag) begin
                        state_d  = ST_LOAD;
                        accept   = 1'b1;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_CMD1: begin
                if (host_we) begin
                    if (hit.step2)      state_d = ST_CMD2;
                    else if (hit.step1) state_d = ST_CMD1;
                    else                state_d = ST_IDLE;
                end
            end
            ST_CMD2: begin
                if (host_we) begin
                    if (hit.step3) begin
                        state_d     = ST_LOAD;
                        open_unlock = 1'b1;
                        tmr_load    = 1'b1;
                    end else if (hit.step1) begin
                        state_d = ST_CMD1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_LOAD: begin
                if (host_we && load_ok) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                end else if (tmr_zero) begin
                    if (lcnt_q != '0) begin
                        state_d  = ST_PROG;
                        tmr_load = 1'b1;
                        tmr_val  = WC_LD;
                        prot_set = unlock_q;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_PROG: begin
                if (tmr_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and window bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            unlock_q <= 1'b0;
            page_q   <= '0;
            lcnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_LOAD && state_d == ST_LOAD) begin
                unlock_q <= open_unlock;
                lcnt_q   <= accept ? LCNT_W'(1) : '0;
            end else if (accept) begin
                lcnt_q <= lcnt_q + 1'b1;
            end
            if (accept && (state_q != ST_LOAD || lcnt_q == '0)) begin
                page_q <= host_addr[ADDR_W-1:OFS_W];
            end
        end
    end

    // Output register: forwarded byte loads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_we_q   <= 1'b0;
            arr_addr_q <= '0;
            arr_data_q <= '0;
        end else begin
            arr_we_q <= accept;
            if (accept) begin
                arr_addr_q <= host_addr;
                arr_data_q <= host_data;
            end
        end
    end

    assign arr_we   = arr_we_q;
    assign arr_addr = arr_addr_q;
    assign arr_data = arr_data_q;
    assign busy     = (state_q == ST_PROG);
    assign wp_on    = wp_flag;

    AST_NO_STROBE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !arr_we_q); // R10
    AST_LOAD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        lcnt_q <= PAGE_MAX); // R7
    AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_q |-> (arr_addr_q[ADDR_W-1:OFS_W] == page_q)); // R8
    AST_PROG_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (lcnt_q != '0)); // R12
    AST_PROT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && wp_flag && host_we) |=> !arr_we_q); // R5
endmodule

// File: tb/wp_unlock_seq_test.sv
module wp_unlock_seq_test;
    localparam int PB  = 128;
    localparam int BLC = 6;
    localparam int WC  = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [14:0] host_addr = '0;
    logic [7:0]  host_data = '0;
    logic        arr_we, busy, wp_on;
    logic [14:0] arr_addr;
    logic [7:0]  arr_data;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    wp_unlock_seq #(.PAGE_BYTES(PB), .BLC_CYC(BLC), .WC_CYC(WC), .INIT_PROT(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_data(host_data), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_data(arr_data), .busy(busy), .wp_on(wp_on)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One host write; returns the strobe and bus seen one cycle later.
    task automatic wr(input logic [14:0] a, input logic [7:0] d,
                      output bit we, output logic [14:0] oa, output logic [7:0] od);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_data = d;
        @(negedge clk);
        host_we = 1'b0;
        we = arr_we; oa = arr_addr; od = arr_data;
    endtask

    task automatic wr_expect(input logic [14:0] a, input logic [7:0] d,
                             input bit exp_we, input string req);
        bit we; logic [14:0] oa; logic [7:0] od;
        wr(a, d, we, oa, od);
        chk(we == exp_we, req, "strobe", int'(we), int'(exp_we));
        if (exp_we && we) begin
            chk(oa == a, req, "addr", int'(oa), int'(a));
            chk(od == d, req, "data", int'(od), int'(d));
        end
    endtask

    task automatic unlock(input string req);
        wr_expect(15'h5555, 8'hAA, 1'b0, req);
        wr_expect(15'h2AAA, 8'h55, 1'b0, req);
        wr_expect(15'h5555, 8'hA0, 1'b0, req);
    endtask

    // Called at the negedge right after the last accepted load.
    task automatic wait_prog(input int exp_lat, input string req);
        int k = 0;
        int b = 0;
        while (!busy && k < 1000) begin @(negedge clk); k++; end
        if (exp_lat >= 0) chk(k == exp_lat, req, "window close latency", k, exp_lat);
        while (busy && b < 1000) begin @(negedge clk); b++; end
        chk(b == WC, req, "busy length", b, WC);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        chk(arr_we == 1'b0, "R1", "strobe in reset", int'(arr_we), 0);
        chk(wp_on == 1'b0, "R2", "initial flag", int'(wp_on), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    endtask

    task automatic t_unprot_direct();
        wr_expect(15'h0123, 8'h5A, 1'b1, "R3");
        wait_prog(BLC, "R9");
        chk(wp_on == 1'b0, "R3", "flag after direct write", int'(wp_on), 0);
    endtask

    task automatic t_unlock_empty();
        bit saw = 1'b0;
        unlock("R4");
        repeat (BLC + 6) begin
            @(negedge clk);
            if (busy) saw = 1'b1;
        end
        chk(saw == 1'b0, "R12", "busy after empty window", int'(saw), 0);
        chk(wp_on == 1'b0, "R12", "flag after empty window", int'(wp_on), 0);
    endtask

    task automatic t_unlock_page();
        unlock("R4");
        wr_expect(15'h1A80, 8'h11, 1'b1, "R11");
        wr_expect(15'h1A81, 8'h22, 1'b1, "R8");
        wr_expect(15'h2000, 8'h33, 1'b0, "R8");
        wr_expect(15'h1AFF, 8'h44, 1'b1, "R8");
        wait_prog(BLC, "R9");
        chk(wp_on == 1'b1, "R11", "flag after unlocked write", int'(wp_on), 1);
    endtask

    task automatic t_protected();
        wr_expect(15'h0456, 8'h77, 1'b0, "R5");
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(wp_on == 1'b1, "R2", "flag survives reset", int'(wp_on), 1);
        chk(busy == 1'b0, "R1", "busy after second reset", int'(busy), 0);
        wr_expect(15'h0457, 8'h78, 1'b0, "R5");
    endtask

    task automatic t_abort();
        wr_expect(15'h5555, 8'hAA, 1'b0, "R6");
        wr_expect(15'h0000, 8'h12, 1'b0, "R6");
        wr_expect(15'h2AAA, 8'h55, 1'b0, "R6");
        wr_expect(15'h5555, 8'hA0, 1'b0, "R6");
        wr_expect(15'h0300, 8'h9C, 1'b0, "R6");
        wr_expect(15'h5555, 8'hAA, 1'b0, "R6");
        wr_expect(15'h5555, 8'hAA, 1'b0, "R6");
        wr_expect(15'h2AAA, 8'h55, 1'b0, "R6");
        wr_expect(15'h5555, 8'hA0, 1'b0, "R6");
        wr_expect(15'h0300, 8'h9D, 1'b1, "R6");
        wait_prog(BLC, "R9");
    endtask

    task automatic t_overflow_and_busy();
        unlock("R4");
        for (int i = 0; i < PB + 2; i++) begin
            wr_expect(15'h4000 + 15'(i % PB), 8'(i), (i < PB), "R7");
        end
        while (!busy) @(negedge clk);
        unlock("R10");
        wr_expect(15'h0010, 8'hE1, 1'b0, "R10");
        chk(busy == 1'b1, "R10", "still busy", int'(busy), 1);
        while (busy) @(negedge clk);
        wr_expect(15'h0011, 8'hE2, 1'b0, "R10");
        chk(wp_on == 1'b1, "R11", "flag stays set", int'(wp_on), 1);
    endtask

    initial begin
        t_reset();
        t_unprot_direct();
        t_unlock_empty();
        t_unlock_page();
        t_protected();
        t_abort();
        t_overflow_and_busy();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule